// File: doc/BRIEF.md
# Register-Access Command Channel

This block is the host side of a register-access bridge. Software puts one command word on the block. The word carries a direction flag, a halfword register address and, for a write, 16 bits of write data. A controller then presents the request on a plain request/acknowledge backend and reports its progress through a status word. The status word holds the current controller state, the last read data, a sticky error flag for dropped commands, and the init-done input.

A write finishes as soon as the backend acknowledges it. A read goes on to wait for a response pulse and captures the returned data. It then parks, holding that data steady in the status word until software writes a 1 to the separate valid-clear input. The block accepts a command only when it is idle and init-done is high. Any other command is discarded and the error flag is raised.

Top module: `regwrap_cmd_chan`

## Requirements
- R1: After a synchronous active-low reset the status word has state 0 in bits [18:16], read data 0 in bits [15:0] and error 0 in bit 20, and `bkReq` is low.
- R2: A command accepted in the idle state (state code 0, `initDone` high) moves the state to request (code 2) one cycle later. `bkReq` is then high, with `bkWrite` = command bit 31, `bkAddr` = command bits [30:16] (byte address shifted right by one) and `bkWdata` = command bits [15:0].
- R3: In the request state, while `bkAck` is low, the state, `bkReq` and the request fields hold unchanged.
- R4: For a write, `bkAck` in the request state returns the state to idle (code 0) in the next cycle.
- R5: For a read, `bkAck` in the request state moves the state to wait-for-data (code 4) in the next cycle, and `bkReq` falls.
- R6: In wait-for-data, a `bkRespValid` pulse moves the state to wait-for-valid-clear (code 6) and loads `bkRespData` into status bits [15:0] in the next cycle.
- R7: In wait-for-valid-clear the read data stays stable and the state stays 6 until `vldClrWrEn` is high with `vldClrBit` = 1. The state then returns to 0 in the next cycle.
- R8: A valid-clear write in any state other than wait-for-valid-clear, or a valid-clear write with `vldClrBit` = 0, changes neither the state nor the read data.
- R9: A command presented while the state is not idle, or while `initDone` is low, is dropped and leaves the state unchanged. Status bit 20 is set one cycle later and stays set until reset.
- R10: Status bit 21 follows `initDone` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| initDone | input | 1 | Bridge initialisation complete |
| cmdWrEn | input | 1 | Command word write strobe |
| cmdWord | input | 32 | Command: [31] write, [30:16] halfword address, [15:0] data |
| vldClrWrEn | input | 1 | Valid-clear register write strobe |
| vldClrBit | input | 1 | Value written to the valid-clear register |
| statusWord | output | 32 | [21] init-done, [20] error, [18:16] state, [15:0] read data |
| bkReq | output | 1 | Backend request |
| bkWrite | output | 1 | Backend request direction, 1 = write |
| bkAddr | output | 15 | Backend halfword address |
| bkWdata | output | 16 | Backend write data |
| bkAck | input | 1 | Backend accepts the request |
| bkRespValid | input | 1 | Backend read response strobe |
| bkRespData | input | 16 | Backend read response data |

## Verification
Every registered result is due exactly one clock edge after its stimulus. The request state, the backend fields and the dropped-command error appear the cycle after the command strobe. The state moves the cycle after `bkAck`, `bkRespValid` or a valid-clear write, and the captured read data appears together with state 6. Only the init-done bit is combinational. The bench changes inputs just after a rising edge and checks the outputs after the next edge, so each check lands on the cycle the result is due. It also checks in each waiting cycle that the state has not moved early.

// File: rtl/regwrap_pkg.sv
package regwrap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_REQ      = 3'd2,
    ST_WAITDATA = 3'd4,
    ST_WAITCLR  = 3'd6
  } chanState_t;

  typedef struct packed {
    logic loadCmd;
    logic captureRd;
    logic flagDrop;
  } ctrlStrobe_t;

endpackage

// File: rtl/regwrap_ctrl.sv
module regwrap_ctrl
  import regwrap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        initDone,
  input  logic        cmdWrEn,
  input  logic        vldClr,
  input  logic        isWrite,
  input  logic        bkAck,
  input  logic        bkRespValid,
  output chanState_t  stateQ,
  output ctrlStrobe_t strobe,
  output logic        bkReq
);

  chanState_t stateD;

  always_comb begin
    stateD           = stateQ;
    strobe           = '0;
    strobe.flagDrop  = cmdWrEn && !((stateQ == ST_IDLE) && initDone);
    case (stateQ)
      ST_IDLE: begin
        if (cmdWrEn && initDone) begin
          stateD         = ST_REQ;
          strobe.loadCmd = 1'b1;
        end
      end
      ST_REQ: begin
        if (bkAck) stateD = isWrite ? ST_IDLE : ST_WAITDATA;
      end
      ST_WAITDATA: begin
        if (bkRespValid) begin
          stateD           = ST_WAITCLR;
          strobe.captureRd = 1'b1;
        end
      end
      ST_WAITCLR: begin
        if (vldClr) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign bkReq = (stateQ == ST_REQ);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_REQ && !bkAck) |=> (stateQ == ST_REQ));

  assert_write_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_REQ && bkAck && isWrite) |=> (stateQ == ST_IDLE));

  assert_read_wait_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_REQ && bkAck && !isWrite) |=> (stateQ == ST_WAITDATA && !bkReq));

  assert_clr_park_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAITCLR && !vldClr) |=> (stateQ == ST_WAITCLR));

  assert_clr_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAITDATA && vldClr && !bkRespValid) |=> (stateQ == ST_WAITDATA));

  assert_drop_uninit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && cmdWrEn && !initDone) |=> (stateQ == ST_IDLE));

endmodule

// File: rtl/regwrap_datapath.sv
module regwrap_datapath
  import regwrap_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  localparam int CMD_W = 1 + ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  chanState_t        stateQ,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic [DATA_W-1:0] bkRespData,
  output logic              cmdWriteQ,
  output logic [ADDR_W-1:0] cmdAddrQ,
  output logic [DATA_W-1:0] cmdDataQ,
  output logic [DATA_W-1:0] rdDataQ,
  output logic              errQ
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdWriteQ <= 1'b0;
      cmdAddrQ  <= '0;
      cmdDataQ  <= '0;
    end else if (strobe.loadCmd) begin
      cmdWriteQ <= cmdWord[CMD_W-1];
      cmdAddrQ  <= cmdWord[CMD_W-2:DATA_W];
      cmdDataQ  <= cmdWord[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 rdDataQ <= '0;
    else if (strobe.captureRd) rdDataQ <= bkRespData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                errQ <= 1'b0;
    else if (strobe.flagDrop) errQ <= 1'b1;
  end

  assert_req_fields_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_REQ) |=> ($stable(cmdAddrQ) && $stable(cmdDataQ) && $stable(cmdWriteQ)));

  assert_rd_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAITCLR) |=> $stable(rdDataQ));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ);

endmodule

// File: rtl/regwrap_cmd_chan.sv
module regwrap_cmd_chan
  import regwrap_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  localparam int CMD_W    = 1 + ADDR_W + DATA_W,
  localparam int STATE_LO = DATA_W,
  localparam int ERR_BIT  = DATA_W + 4,
  localparam int INIT_BIT = DATA_W + 5,
  localparam int STAT_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initDone,
  input  logic              cmdWrEn,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              vldClrWrEn,
  input  logic              vldClrBit,
  output logic [STAT_W-1:0] statusWord,
  output logic              bkReq,
  output logic              bkWrite,
  output logic [ADDR_W-1:0] bkAddr,
  output logic [DATA_W-1:0] bkWdata,
  input  logic              bkAck,
  input  logic              bkRespValid,
  input  logic [DATA_W-1:0] bkRespData
);

  chanState_t  stateQ;
  ctrlStrobe_t strobe;
  logic [DATA_W-1:0] rdDataQ;
  logic errQ;
  logic vldClr;

  assign vldClr = vldClrWrEn && vldClrBit;

  regwrap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .initDone(initDone), .cmdWrEn(cmdWrEn),
    .vldClr(vldClr), .isWrite(bkWrite), .bkAck(bkAck),
    .bkRespValid(bkRespValid), .stateQ(stateQ), .strobe(strobe), .bkReq(bkReq)
  );

  regwrap_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stateQ(stateQ),
    .cmdWord(cmdWord), .bkRespData(bkRespData), .cmdWriteQ(bkWrite),
    .cmdAddrQ(bkAddr), .cmdDataQ(bkWdata), .rdDataQ(rdDataQ), .errQ(errQ)
  );

  always_comb begin
    statusWord                          = '0;
    statusWord[DATA_W-1:0]              = rdDataQ;
    statusWord[STATE_LO+2:STATE_LO]     = stateQ;
    statusWord[ERR_BIT]                 = errQ;
    statusWord[INIT_BIT]                = initDone;
  end

  assert_req_out_R2: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[STATE_LO+2:STATE_LO] == 3'd0 && cmdWrEn && initDone) |=> bkReq);

  assert_init_mirror_R10: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[INIT_BIT] == initDone);

endmodule

// File: tb/regwrap_cmd_chan_bench.sv
module regwrap_cmd_chan_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initDone = 1'b0;
  logic cmdWrEn = 1'b0;
  logic [31:0] cmdWord = '0;
  logic vldClrWrEn = 1'b0;
  logic vldClrBit = 1'b0;
  logic [31:0] statusWord;
  logic bkReq, bkWrite;
  logic [14:0] bkAddr;
  logic [15:0] bkWdata;
  logic bkAck = 1'b0;
  logic bkRespValid = 1'b0;
  logic [15:0] bkRespData = '0;

  int testCnt = 0;
  int failCnt = 0;
  int cycles = 0;
  logic [15:0] lastRd = '0;

  regwrap_cmd_chan u_regwrap_cmd_chan (
    .clk(clk), .rstN(rstN), .initDone(initDone), .cmdWrEn(cmdWrEn),
    .cmdWord(cmdWord), .vldClrWrEn(vldClrWrEn), .vldClrBit(vldClrBit),
    .statusWord(statusWord), .bkReq(bkReq), .bkWrite(bkWrite),
    .bkAddr(bkAddr), .bkWdata(bkWdata), .bkAck(bkAck),
    .bkRespValid(bkRespValid), .bkRespData(bkRespData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failCnt++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  function automatic logic [31:0] mkCmd(logic wr, logic [15:0] byteAddr, logic [15:0] data);
    return {wr, byteAddr[15:1], data};
  endfunction

  function automatic logic [2:0] stOf(logic [31:0] s);
    return s[18:16];
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; step(); step(); rstN = 1'b1;
    lastRd = '0;
  endtask

  task automatic issue(logic [31:0] c);
    cmdWrEn = 1'b1; cmdWord = c; step(); cmdWrEn = 1'b0;
  endtask

  task automatic doWrite(logic [15:0] a, logic [15:0] d, int ackDly);
    issue(mkCmd(1'b1, a, d));
    chk("R2 state", stOf(statusWord), 3'd2);
    chk("R2 fields", {bkReq, bkWrite, bkAddr, bkWdata}, {1'b1, 1'b1, a[15:1], d});
    for (int i = 0; i < ackDly; i++) begin
      step();
      chk("R3 hold", {stOf(statusWord), bkReq, bkAddr, bkWdata}, {3'd2, 1'b1, a[15:1], d});
    end
    bkAck = 1'b1; step(); bkAck = 1'b0;
    chk("R4 idle", {stOf(statusWord), bkReq}, {3'd0, 1'b0});
    chk("R4 rd kept", statusWord[15:0], lastRd);
  endtask

  task automatic doRead(logic [15:0] a, logic [15:0] r, int ackDly, int rspDly, int clrDly);
    issue(mkCmd(1'b0, a, 16'h0));
    chk("R2 state", stOf(statusWord), 3'd2);
    chk("R2 fields", {bkReq, bkWrite, bkAddr}, {1'b1, 1'b0, a[15:1]});
    for (int i = 0; i < ackDly; i++) begin
      step();
      chk("R3 hold", {stOf(statusWord), bkReq}, {3'd2, 1'b1});
    end
    bkAck = 1'b1; step(); bkAck = 1'b0;
    chk("R5 wait", {stOf(statusWord), bkReq}, {3'd4, 1'b0});
    for (int i = 0; i < rspDly; i++) begin
      vldClrWrEn = 1'b1; vldClrBit = 1'b1; step(); vldClrWrEn = 1'b0;
      chk("R8 clr in wait-data", {stOf(statusWord), statusWord[15:0]}, {3'd4, lastRd});
    end
    bkRespValid = 1'b1; bkRespData = r; step(); bkRespValid = 1'b0; bkRespData = ~r;
    lastRd = r;
    chk("R6 park", {stOf(statusWord), statusWord[15:0]}, {3'd6, r});
    for (int i = 0; i < clrDly; i++) begin
      vldClrWrEn = (i % 2 == 0); vldClrBit = 1'b0; step(); vldClrWrEn = 1'b0;
      chk("R7 hold", {stOf(statusWord), statusWord[15:0]}, {3'd6, r});
    end
    vldClrWrEn = 1'b1; vldClrBit = 1'b1; step(); vldClrWrEn = 1'b0; vldClrBit = 1'b0;
    chk("R7 clear", {stOf(statusWord), statusWord[15:0]}, {3'd0, r});
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed);
    doReset();
    chk("R1 reset", {stOf(statusWord), statusWord[20], statusWord[15:0], bkReq}, {3'd0, 1'b0, 16'h0, 1'b0});
    chk("R10 init low", statusWord[21], 1'b0);

    // R9: command while init-done is low is dropped
    issue(mkCmd(1'b1, 16'h0010, 16'hABCD));
    chk("R9 uninit drop", {stOf(statusWord), bkReq, statusWord[20]}, {3'd0, 1'b0, 1'b1});
    doReset();
    chk("R1 err cleared", statusWord[20], 1'b0);
    initDone = 1'b1; #1;
    chk("R10 init high", statusWord[21], 1'b1);

    // R8: valid-clear while idle
    vldClrWrEn = 1'b1; vldClrBit = 1'b1; step(); vldClrWrEn = 1'b0;
    chk("R8 clr in idle", {stOf(statusWord), statusWord[15:0]}, {3'd0, 16'h0});

    doRead(16'h1234, 16'hBEEF, 2, 1, 3);
    doWrite(16'hFFFE, 16'h5A5A, 0);

    // R9: command while busy; R8: valid-clear while in request
    issue(mkCmd(1'b0, 16'h0002, 16'h0));
    issue(mkCmd(1'b1, 16'h0444, 16'h1111));
    chk("R9 busy drop", {stOf(statusWord), bkWrite, bkAddr, statusWord[20]}, {3'd2, 1'b0, 15'h0001, 1'b1});
    vldClrWrEn = 1'b1; vldClrBit = 1'b1; step(); vldClrWrEn = 1'b0;
    chk("R8 clr in req", stOf(statusWord), 3'd2);
    bkAck = 1'b1; step(); bkAck = 1'b0;
    bkRespValid = 1'b1; bkRespData = 16'h0F0F; step(); bkRespValid = 1'b0;
    lastRd = 16'h0F0F;
    issue(mkCmd(1'b1, 16'h0008, 16'h2222));
    chk("R9 drop in park", {stOf(statusWord), statusWord[15:0]}, {3'd6, 16'h0F0F});
    vldClrWrEn = 1'b1; vldClrBit = 1'b1; step(); vldClrWrEn = 1'b0;
    chk("R7 recover", stOf(statusWord), 3'd0);
    chk("R9 sticky", statusWord[20], 1'b1);

    for (int n = 0; n < 40; n++) begin
      logic [15:0] a, d;
      a = 16'($urandom()) & 16'hFFFE;
      d = 16'($urandom());
      if ($urandom() % 2 == 0)
        doRead(a, d, int'($urandom() % 4), int'($urandom() % 3), int'($urandom() % 3));
      else
        doWrite(a, d, int'($urandom() % 4));
    end
    chk("R9 still sticky", statusWord[20], 1'b1);

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule